// File: doc/BRIEF.md
# Page Access Permission Checker

The checker takes the rights gathered along a completed page-table walk (user, writable, no-execute), the kind of access being attempted, the leaf entry's protection key and the processor's control enables, and decides whether the access may proceed. The supervisor execution-prevention and access-prevention rules are applied, as well as the write-protect rule for supervisor writes and the per-key access-disable and write-disable rights taken from two 32-bit key-rights registers. One register serves user pages and the other serves supervisor pages.

The decision and the two error-code bits it produces are registered once. A walker presents the inputs in one cycle and reads the verdict in the next. The walk itself, and the present and reserved-bit faults it raises, are outside this block.

Top module: `pac_checker`

## Requirements
- R1: An instruction fetch is denied whenever the accumulated no-execute right `rt_nx_i` is 1.
- R2: A user-mode access is denied when `rt_user_i` is 0. A user-mode write is denied when `rt_rw_i` is 0.
- R3: A supervisor instruction fetch from a page with `rt_user_i`=1 is denied when `en_smep_i` is 1, and is not denied by this rule otherwise.
- R4: A supervisor data access to a page with `rt_user_i`=1 is denied when `en_smap_i` is 1 and either `acc_implicit_i` is 1 or `ac_flag_i` is 0.
- R5: A supervisor write to a page with `rt_rw_i`=0 is denied only when `en_wp_i` is 1.
- R6: The key check applies only to data accesses. It uses `ukey_rights_i` when `en_pku_i` is 1 and `rt_user_i` is 1, and it uses `skey_rights_i` when `en_pks_i` is 1 and `rt_user_i` is 0.
- R7: The rights of key k are bits [2k+1:2k] of the selected register. Bit 2k is access-disable and denies any access. Bit 2k+1 is write-disable and denies a write when the access is user mode or `en_wp_i` is 1.
- R8: `err_pkey_o` is 1 exactly when the key check denies the access, and in that case `allow_o` is 0.
- R9: `err_fetch_o` is 1 exactly when the access is an instruction fetch and either `en_nx_i` or `en_smep_i` is 1.
- R10: When `acc_implicit_i` is 1, `acc_user_i` and `acc_fetch_i` are ignored and the access is treated as a supervisor data access.
- R11: Outputs reflect the inputs of the previous clock cycle. While `rst_ni` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_user_i | input | 1 | Access made in user mode |
| acc_write_i | input | 1 | Access is a write |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_implicit_i | input | 1 | Implicit supervisor data access |
| rt_user_i | input | 1 | Accumulated user right (AND over levels) |
| rt_rw_i | input | 1 | Accumulated writable right (AND over levels) |
| rt_nx_i | input | 1 | Accumulated no-execute right (OR over levels) |
| leaf_key_i | input | 4 | Protection key of the leaf entry |
| en_nx_i | input | 1 | No-execute enabled |
| en_smep_i | input | 1 | Supervisor execution prevention enabled |
| en_smap_i | input | 1 | Supervisor access prevention enabled |
| en_wp_i | input | 1 | Supervisor write protect enabled |
| en_pku_i | input | 1 | Keys on user pages enabled |
| en_pks_i | input | 1 | Keys on supervisor pages enabled |
| ac_flag_i | input | 1 | Alignment-check flag (overrides prevention for explicit data) |
| ukey_rights_i | input | 32 | Key-rights register for user pages |
| skey_rights_i | input | 32 | Key-rights register for supervisor pages |
| allow_o | output | 1 | Access permitted |
| err_fetch_o | output | 1 | Error-code fetch bit |
| err_pkey_o | output | 1 | Error-code protection-key bit |

## Verification
The assertions assume that the inputs are settled and meaningful in every cycle after reset, because the block has no valid qualifier. They also assume that an implicit access may arrive with the user or fetch flag set, and the block must then ignore those flags. The stimulus sweeps every combination of access flags, rights, enables and the AC flag. The key, and two key-rights registers built from different bit patterns, change with each vector, so the illegal implicit combinations are driven on purpose. A second sweep sets every key to each of the four rights values under both registers, so every field position is exercised.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int unsigned KEY_W    = 4;
  localparam int unsigned FIELD_W  = 2;
  localparam int unsigned NUM_KEYS = 1 << KEY_W;
  localparam int unsigned KREG_W   = NUM_KEYS * FIELD_W;
  localparam int unsigned AD_BIT   = 0;
  localparam int unsigned WD_BIT   = 1;

  typedef struct packed {
    logic user;
    logic write;
    logic fetch;
    logic implicit;
  } acc_t;

  typedef struct packed {
    logic user;
    logic rw;
    logic nx;
  } rights_t;

  typedef struct packed {
    logic nx;
    logic smep;
    logic smap;
    logic wp;
    logic pku;
    logic pks;
  } ctl_t;

  typedef struct packed {
    logic allow;
    logic err_fetch;
    logic err_pkey;
  } verdict_t;
endpackage

// File: rtl/pac_access_norm.sv
module pac_access_norm
  import pac_pkg::*;
(
  input  acc_t raw_i,
  input  logic en_nx_i,
  input  logic en_smep_i,
  output acc_t acc_o,
  output logic err_fetch_o
);
  // implicit accesses are supervisor data by definition
  always_comb begin
    acc_o          = raw_i;
    acc_o.user     = raw_i.user  & ~raw_i.implicit;
    acc_o.fetch    = raw_i.fetch & ~raw_i.implicit;
  end

  assign err_fetch_o = acc_o.fetch & (en_nx_i | en_smep_i);
endmodule

// File: rtl/pac_key_rights.sv
module pac_key_rights
  import pac_pkg::*;
#(
  parameter int unsigned KW = KEY_W,
  parameter int unsigned FW = FIELD_W,
  localparam int unsigned NK = 1 << KW,
  localparam int unsigned RW = NK * FW
) (
  input  logic [KW-1:0] key_i,
  input  logic          user_page_i,
  input  logic [RW-1:0] ureg_i,
  input  logic [RW-1:0] sreg_i,
  output logic [FW-1:0] field_o
);
  logic [RW-1:0] reg_sel;
  logic [FW-1:0] fields [NK];

  assign reg_sel = user_page_i ? ureg_i : sreg_i;

  for (genvar g = 0; g < NK; g++) begin : g_field
    assign fields[g] = reg_sel[g*FW +: FW];
  end

  assign field_o = fields[key_i];
endmodule

// File: rtl/pac_rights_eval.sv
module pac_rights_eval
  import pac_pkg::*;
(
  input  acc_t            acc_i,
  input  rights_t         rt_i,
  input  ctl_t            ctl_i,
  input  logic            ac_i,
  input  logic [FIELD_W-1:0] key_field_i,
  output logic            allow_o,
  output logic            pkey_deny_o
);
  logic pk_on, pk_ad, pk_wd;
  logic nx_deny, usr_deny, smep_deny, smap_deny, wp_deny;

  assign pk_on = ~acc_i.fetch & (rt_i.user ? ctl_i.pku : ctl_i.pks);
  assign pk_ad = key_field_i[AD_BIT];
  assign pk_wd = key_field_i[WD_BIT] & acc_i.write & (acc_i.user | ctl_i.wp);
  assign pkey_deny_o = pk_on & (pk_ad | pk_wd);

  assign nx_deny   = acc_i.fetch & rt_i.nx;
  assign usr_deny  = acc_i.user & (~rt_i.user | (acc_i.write & ~rt_i.rw));
  assign smep_deny = ~acc_i.user & rt_i.user & acc_i.fetch & ctl_i.smep;
  assign smap_deny = ~acc_i.user & rt_i.user & ~acc_i.fetch & ctl_i.smap
                   & (acc_i.implicit | ~ac_i);
  assign wp_deny   = ~acc_i.user & acc_i.write & ~rt_i.rw & ctl_i.wp;

  assign allow_o = ~(pkey_deny_o | nx_deny | usr_deny | smep_deny
                     | smap_deny | wp_deny);
endmodule

// File: rtl/pac_checker.sv
module pac_checker
  import pac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_user_i,
  input  logic              acc_write_i,
  input  logic              acc_fetch_i,
  input  logic              acc_implicit_i,
  input  logic              rt_user_i,
  input  logic              rt_rw_i,
  input  logic              rt_nx_i,
  input  logic [KEY_W-1:0]  leaf_key_i,
  input  logic              en_nx_i,
  input  logic              en_smep_i,
  input  logic              en_smap_i,
  input  logic              en_wp_i,
  input  logic              en_pku_i,
  input  logic              en_pks_i,
  input  logic              ac_flag_i,
  input  logic [KREG_W-1:0] ukey_rights_i,
  input  logic [KREG_W-1:0] skey_rights_i,
  output logic              allow_o,
  output logic              err_fetch_o,
  output logic              err_pkey_o
);
  acc_t     acc_raw, acc_n;
  rights_t  rt;
  ctl_t     ctl;
  verdict_t vd_d, vd_q;
  logic [FIELD_W-1:0] key_field;
  logic fetch_err, allow_c, pk_deny;

  assign acc_raw = '{user: acc_user_i, write: acc_write_i,
                     fetch: acc_fetch_i, implicit: acc_implicit_i};
  assign rt  = '{user: rt_user_i, rw: rt_rw_i, nx: rt_nx_i};
  assign ctl = '{nx: en_nx_i, smep: en_smep_i, smap: en_smap_i,
                 wp: en_wp_i, pku: en_pku_i, pks: en_pks_i};

  pac_access_norm u_norm (
    .raw_i       (acc_raw),
    .en_nx_i     (en_nx_i),
    .en_smep_i   (en_smep_i),
    .acc_o       (acc_n),
    .err_fetch_o (fetch_err)
  );

  pac_key_rights #(.KW(KEY_W), .FW(FIELD_W)) u_keys (
    .key_i       (leaf_key_i),
    .user_page_i (rt_user_i),
    .ureg_i      (ukey_rights_i),
    .sreg_i      (skey_rights_i),
    .field_o     (key_field)
  );

  pac_rights_eval u_eval (
    .acc_i       (acc_n),
    .rt_i        (rt),
    .ctl_i       (ctl),
    .ac_i        (ac_flag_i),
    .key_field_i (key_field),
    .allow_o     (allow_c),
    .pkey_deny_o (pk_deny)
  );

  assign vd_d = '{allow: allow_c, err_fetch: fetch_err, err_pkey: pk_deny};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vd_q <= '0;
    else         vd_q <= vd_d;
  end

  assign allow_o     = vd_q.allow;
  assign err_fetch_o = vd_q.err_fetch;
  assign err_pkey_o  = vd_q.err_pkey;
endmodule

// File: rtl/pac_checker_sva.sv
module pac_checker_sva
  import pac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_user_i,
  input logic              acc_write_i,
  input logic              acc_fetch_i,
  input logic              acc_implicit_i,
  input logic              rt_user_i,
  input logic              rt_rw_i,
  input logic              rt_nx_i,
  input logic [KEY_W-1:0]  leaf_key_i,
  input logic              en_nx_i,
  input logic              en_smep_i,
  input logic              en_smap_i,
  input logic              en_wp_i,
  input logic              en_pku_i,
  input logic              en_pks_i,
  input logic              ac_flag_i,
  input logic [KREG_W-1:0] ukey_rights_i,
  input logic [KREG_W-1:0] skey_rights_i,
  input logic              allow_o,
  input logic              err_fetch_o,
  input logic              err_pkey_o
);
  AST_FETCH_NX_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fetch_i && !acc_implicit_i && rt_nx_i) |=> !allow_o); // R1

  AST_USER_SUP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_user_i && !acc_implicit_i && !rt_user_i) |=> !allow_o); // R2

  AST_SMEP_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_user_i && acc_fetch_i && !acc_implicit_i && rt_user_i && en_smep_i)
      |=> !allow_o); // R3

  AST_SMAP_IMPLICIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_implicit_i && rt_user_i && en_smap_i) |=> !allow_o); // R4

  AST_PKEY_NOT_ALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pkey_o |-> !allow_o); // R8

  AST_FETCH_NO_PKEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_fetch_i && !acc_implicit_i) |=> !err_pkey_o); // R6

  AST_KEYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_pku_i && !en_pks_i) |=> !err_pkey_o); // R6

  AST_FETCH_ERR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_nx_i && !en_smep_i) |=> !err_fetch_o); // R9

  AST_IMPLICIT_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_implicit_i |=> !err_fetch_o); // R10
endmodule

bind pac_checker pac_checker_sva u_sva (.*);

// File: tb/tb_pac_checker.sv
`timescale 1ns/1ps
module tb_pac_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_user, a_write, a_fetch, a_impl;
  logic r_user, r_rw, r_nx;
  logic [3:0] key;
  logic e_nx, e_smep, e_smap, e_wp, e_pku, e_pks, ac;
  logic [31:0] ureg, sreg;
  logic allow, efetch, epkey;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pac_checker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_user_i(a_user), .acc_write_i(a_write), .acc_fetch_i(a_fetch),
    .acc_implicit_i(a_impl),
    .rt_user_i(r_user), .rt_rw_i(r_rw), .rt_nx_i(r_nx),
    .leaf_key_i(key),
    .en_nx_i(e_nx), .en_smep_i(e_smep), .en_smap_i(e_smap), .en_wp_i(e_wp),
    .en_pku_i(e_pku), .en_pks_i(e_pks), .ac_flag_i(ac),
    .ukey_rights_i(ureg), .skey_rights_i(sreg),
    .allow_o(allow), .err_fetch_o(efetch), .err_pkey_o(epkey)
  );

  logic x_allow, x_efetch, x_epkey;
  string x_tag;

  task automatic expect_bit(input logic act, input logic exp, input string tag,
                            input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b (acc u%b w%b f%b i%b rt u%b rw%b nx%b key%0d en nx%b smep%b smap%b wp%b pku%b pks%b ac%b)",
               tag, what, act, exp, a_user, a_write, a_fetch, a_impl,
               r_user, r_rw, r_nx, key, e_nx, e_smep, e_smap, e_wp,
               e_pku, e_pks, ac);
    end
  endtask

  // reference model of the requirements
  task automatic model();
    logic u, f, w, key_on, ad, wd, pk;
    logic [31:0] kr;
    u = a_user && !a_impl;   // R10
    f = a_fetch && !a_impl;  // R10
    w = a_write;
    kr = r_user ? ureg : sreg;
    ad = kr[2*key];
    wd = kr[2*key+1];
    key_on = !f && (r_user ? e_pku : e_pks);
    pk = key_on && (ad || (wd && w && (u || e_wp)));
    x_epkey = pk;
    x_efetch = f && (e_nx || e_smep);
    x_allow = 1'b1;
    x_tag = "R6";
    if (pk) begin x_allow = 0; x_tag = "R7"; end
    else if (f && r_nx) begin x_allow = 0; x_tag = "R1"; end
    else if (u) begin
      if (!r_user || (w && !r_rw)) begin x_allow = 0; x_tag = "R2"; end
    end else begin
      if (r_user && f && e_smep) begin x_allow = 0; x_tag = "R3"; end
      else if (r_user && !f && e_smap && (a_impl || !ac)) begin
        x_allow = 0; x_tag = "R4";
      end else if (w && !r_rw && e_wp) begin x_allow = 0; x_tag = "R5"; end
      else if (w && !r_rw) x_tag = "R5";
    end
    if (a_impl && (a_user || a_fetch)) x_tag = "R10";
  endtask

  task automatic check_all();
    model();
    expect_bit(allow, x_allow, x_tag, "allow_o");
    expect_bit(epkey, x_epkey, "R8", "err_pkey_o");
    expect_bit(efetch, x_efetch, "R9", "err_fetch_o");
  endtask

  initial begin
    {a_user, a_write, a_fetch, a_impl, r_user, r_rw, r_nx} = '0;
    {e_nx, e_smep, e_smap, e_wp, e_pku, e_pks, ac} = '0;
    key = '0; ureg = '1; sreg = '1;
    #12;
    expect_bit(allow, 1'b0, "R11", "reset allow_o");
    expect_bit(efetch, 1'b0, "R11", "reset err_fetch_o");
    expect_bit(epkey, 1'b0, "R11", "reset err_pkey_o");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // full sweep over flags, rights, enables and AC; key and registers vary
    for (int i = 0; i < 16384; i++) begin
      {a_user, a_write, a_fetch, a_impl} = 4'(i);
      {r_user, r_rw, r_nx} = 3'(i >> 4);
      {e_nx, e_smep, e_smap, e_wp, e_pku, e_pks} = 6'(i >> 7);
      ac = i[13];
      key = 4'(i ^ (i >> 4) ^ (i >> 9));
      ureg = 32'hA5C3_1E96 ^ (32'(i) * 32'h9E37_79B9);
      sreg = 32'h3C69_D2B4 ^ (32'(i) * 32'h85EB_CA6B);
      @(negedge clk);
      check_all(); // R11 one-cycle latency applies to every vector
    end

    // key field sweep: every key, every rights value, both registers (R7)
    for (int k = 0; k < 16; k++) begin
      for (int v = 0; v < 4; v++) begin
        for (int m = 0; m < 32; m++) begin
          key = 4'(k);
          ureg = 32'h5555_5555 ^ (32'(v) << (2*k)) ^ (32'h1 << (2*k)) ^ (32'h1 << (2*k));
          ureg[2*k +: 2] = 2'(v);
          sreg = 32'hFFFF_FFFF;
          sreg[2*k +: 2] = 2'(3 - v);
          {r_user, a_user, a_write, e_wp, e_pks} = 5'(m);
          e_pku = 1'b1; a_fetch = 0; a_impl = 0; r_rw = 1; r_nx = 0;
          e_smap = 0; e_smep = 0; e_nx = 1; ac = 1;
          @(negedge clk);
          check_all();
        end
      end
    end

    // R10: implicit access with user/fetch set behaves as supervisor data
    a_impl = 1; a_user = 1; a_fetch = 1; a_write = 0;
    r_user = 1; r_rw = 1; r_nx = 1; e_smap = 0; e_smep = 1; e_nx = 1;
    e_pku = 0; e_pks = 0; ac = 1; e_wp = 0;
    @(negedge clk);
    expect_bit(allow, 1'b1, "R10", "implicit allow_o");
    expect_bit(efetch, 1'b0, "R10", "implicit err_fetch_o");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule